// File: doc/BRIEF.md
# General-Purpose Strobe Port Controller

This block drives one general-purpose strobe pin from a host I/O bus that reaches its registers through an index/data pair. The host first writes a register number to the index port. It then reads or writes the data port. A two-bit mode field in an extension control register turns the pin into one of two strobes.

- **Write strobe:** the pin follows the host write pulse, so an external latch captures the data.
- **Read strobe:** the pin follows the host read pulse, so an external buffer drives the upper data byte.

The block also holds a shadow copy of the external data register. In write-strobe mode that copy answers reads. A control bit selects whether the pin is driven push-pull or open-drain.

The host signals are synchronous to `clk_i`. A register write commits on the first clock edge that samples `iow_ni` high after it was low. It uses the port select and data sampled on the last low cycle. The strobe and the read data are combinational from the registered state and the live bus signals, so no clock edge delays them.

Top module: `gpstb_port_ctrl`

## Requirements
- R1: After reset the index, the extension control register and the shadow register are zero. The pin is released (`stb_oe_o`=0), and with no access in progress `rdata_o` and `rd_be_o` are zero.
- R2: A write with `port_i`=0 loads the index from the low 8 data bits. A read with `port_i`=0 returns the index. Index 0x0B reaches the extension control register through the data port (`port_i`=1), and every write commits on the edge that first samples `iow_ni` high again.
- R3: Control bits 4:3 select the mode: 2'b10 makes the pin a write strobe, 2'b01 a read strobe, and 2'b00 or 2'b11 leaves it inactive.
- R4: In write-strobe mode the pin is asserted (pulled low) in exactly those cycles in which `iow_ni` is low, `port_i` is 1 and the index is 0x0A.
- R5: A data-port write with index 0x0A loads the shadow register in every mode. A read in the same cycle that the write pulse ends still returns the previous value.
- R6: In write-strobe mode a data-port read of index 0x0A returns the full 16-bit shadow value with both byte enables set.
- R7: In read-strobe mode the pin is asserted exactly while `ior_ni` is low, `port_i` is 1 and the index is 0x0A. During such a read `rd_be_o`=2'b01, the upper byte of `rdata_o` is zero and the lower byte is the shadow's lower byte.
- R8: With control bit 2 set, the pin is push-pull: `stb_oe_o`=1 always and `stb_o` is low only while the strobe is asserted. With bit 2 clear, the pin is open-drain: `stb_o`=0 always and `stb_oe_o`=1 only while asserted.
- R9: In modes 2'b00 and 2'b11 the pin is never asserted, and index 0x0A reads back as an ordinary 16-bit register.
- R10: Accesses to indices other than 0x0A never assert the pin. Indices other than 0x0A and 0x0B read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; host bus signals are synchronous to it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_i | input | 1 | 0 selects the index port, 1 the data port |
| wdata_i | input | 16 | Host write data |
| iow_ni | input | 1 | Active-low host write pulse |
| ior_ni | input | 1 | Active-low host read pulse |
| rdata_o | output | 16 | Read data, zero in released byte lanes |
| rd_be_o | output | 2 | Byte lanes the block drives during a read |
| stb_o | output | 1 | Strobe pin output level |
| stb_oe_o | output | 1 | Strobe pin output enable |

## Verification
Two functions can fall in the same cycle:

- **Shadow commit and readback.** The end of a write pulse to index 0x0A can coincide with the start of a read of the same register. The bench raises `iow_ni` and lowers `ior_ni` together and expects the old shadow value in that cycle and the new one on the next.
- **Mode change and strobe.** A write that changes the mode commits in the same edge that the next access may begin. The bench checks that the pin follows the new mode only from the following cycle on.

Random bus traffic, compared each cycle against a behavioural model, adds further overlaps of reads, writes and index changes.

// File: rtl/gpstb_pkg.sv
package gpstb_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_RD   = 2'b01,
    MODE_WR   = 2'b10,
    MODE_OFF2 = 2'b11
  } gp_mode_e;

  localparam int unsigned CTRL_MODE_LSB = 3;
  localparam int unsigned CTRL_DRV_BIT  = 2;
endpackage

// File: rtl/gpstb_regs.sv
module gpstb_regs #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned XDATA_IDX = 10,
  parameter int unsigned XCTRL_IDX = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              iow_ni,
  output logic [IDX_W-1:0]  idx_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] shadow_q
);
  logic              iow_q;
  logic              port_c;
  logic [DATA_W-1:0] wd_c;
  logic              wr_done;

  // commit on first sample of the released write pulse
  assign wr_done = !iow_q && iow_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iow_q    <= 1'b1;
      port_c   <= 1'b0;
      wd_c     <= '0;
      idx_q    <= '0;
      ctrl_q   <= '0;
      shadow_q <= '0;
    end else begin
      iow_q <= iow_ni;
      if (!iow_ni) begin
        port_c <= port_i;
        wd_c   <= wdata_i;
      end
      if (wr_done) begin
        if (!port_c) begin
          idx_q <= wd_c[IDX_W-1:0];
        end else if (idx_q == IDX_W'(XDATA_IDX)) begin
          shadow_q <= wd_c;
        end else if (idx_q == IDX_W'(XCTRL_IDX)) begin
          ctrl_q <= wd_c[CTRL_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/gpstb_strobe.sv
module gpstb_strobe
  import gpstb_pkg::*;
(
  input  gp_mode_e mode_i,
  input  logic     drv_pp_i,
  input  logic     hit_i,
  input  logic     iow_ni,
  input  logic     ior_ni,
  output logic     stb_o,
  output logic     stb_oe_o
);
  logic active;

  always_comb begin
    unique case (mode_i)
      MODE_WR: active = hit_i && !iow_ni;
      MODE_RD: active = hit_i && !ior_ni;
      default: active = 1'b0;
    endcase
  end

  always_comb begin
    if (drv_pp_i) begin
      stb_oe_o = 1'b1;
      stb_o    = !active;
    end else begin
      stb_oe_o = active;
      stb_o    = 1'b0;
    end
  end
endmodule

// File: rtl/gpstb_rdmux.sv
module gpstb_rdmux
  import gpstb_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned XDATA_IDX = 10,
  parameter int unsigned XCTRL_IDX = 11,
  localparam int unsigned NLANE    = DATA_W / 8
) (
  input  logic              port_i,
  input  logic              ior_ni,
  input  logic              hit_i,
  input  gp_mode_e          mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] shadow_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NLANE-1:0]  rd_be_o
);
  logic [DATA_W-1:0] val;
  logic              rd_act;
  logic              ext_rd;
  logic [NLANE-1:0]  lane_en;

  assign rd_act = !ior_ni;
  // external buffer owns the top lane during a read strobe
  assign ext_rd = (mode_i == MODE_RD) && hit_i;

  always_comb begin
    val = '0;
    if (!port_i) begin
      val[IDX_W-1:0] = idx_i;
    end else if (idx_i == IDX_W'(XDATA_IDX)) begin
      val = shadow_i;
    end else if (idx_i == IDX_W'(XCTRL_IDX)) begin
      val[CTRL_W-1:0] = ctrl_i;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    if (g == NLANE - 1) begin : g_ext
      assign lane_en[g] = rd_act && !ext_rd;
    end else begin : g_int
      assign lane_en[g] = rd_act;
    end
    assign rdata_o[g*8 +: 8] = lane_en[g] ? val[g*8 +: 8] : 8'h00;
  end

  assign rd_be_o = lane_en;
endmodule

// File: rtl/gpstb_port_ctrl.sv
module gpstb_port_ctrl
  import gpstb_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned XDATA_IDX = 10,
  parameter int unsigned XCTRL_IDX = 11,
  localparam int unsigned NLANE    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              iow_ni,
  input  logic              ior_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NLANE-1:0]  rd_be_o,
  output logic              stb_o,
  output logic              stb_oe_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] shadow_q;
  gp_mode_e          mode_w;
  logic              drv_pp_w;
  logic              hit_w;

  assign mode_w   = gp_mode_e'(ctrl_q[CTRL_MODE_LSB +: 2]);
  assign drv_pp_w = ctrl_q[CTRL_DRV_BIT];
  assign hit_w    = port_i && (idx_q == IDX_W'(XDATA_IDX));

  gpstb_regs #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_W(CTRL_W),
    .XDATA_IDX(XDATA_IDX), .XCTRL_IDX(XCTRL_IDX)
  ) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .port_i  (port_i),
    .wdata_i (wdata_i),
    .iow_ni  (iow_ni),
    .idx_q   (idx_q),
    .ctrl_q  (ctrl_q),
    .shadow_q(shadow_q)
  );

  gpstb_strobe strobe_i (
    .mode_i  (mode_w),
    .drv_pp_i(drv_pp_w),
    .hit_i   (hit_w),
    .iow_ni  (iow_ni),
    .ior_ni  (ior_ni),
    .stb_o   (stb_o),
    .stb_oe_o(stb_oe_o)
  );

  gpstb_rdmux #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_W(CTRL_W),
    .XDATA_IDX(XDATA_IDX), .XCTRL_IDX(XCTRL_IDX)
  ) rdmux_i (
    .port_i  (port_i),
    .ior_ni  (ior_ni),
    .hit_i   (hit_w),
    .mode_i  (mode_w),
    .idx_i   (idx_q),
    .ctrl_i  (ctrl_q),
    .shadow_i(shadow_q),
    .rdata_o (rdata_o),
    .rd_be_o (rd_be_o)
  );
endmodule

// File: rtl/gpstb_port_ctrl_chk.sv
module gpstb_port_ctrl_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned XDATA_IDX = 10,
  localparam int unsigned NLANE    = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              port_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              iow_ni,
  input logic              ior_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NLANE-1:0]  rd_be_o,
  input logic              stb_o,
  input logic              stb_oe_o,
  input logic [IDX_W-1:0]  idx_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] shadow_q
);
  logic       pin_low;
  logic [1:0] mode;
  logic       at_xdata;

  assign pin_low  = stb_oe_o && !stb_o;
  assign mode     = ctrl_q[4:3];
  assign at_xdata = port_i && (idx_q == IDX_W'(XDATA_IDX));

  p_pin_needs_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_low |-> (!iow_ni || !ior_ni));

  p_idle_bus_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iow_ni && ior_ni) |-> (rd_be_o == '0 && rdata_o == '0 && !pin_low));

  p_od_never_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[2] |-> !(stb_oe_o && stb_o));

  p_pp_always_driven_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[2] |-> stb_oe_o);

  p_off_modes_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b00 || mode == 2'b11) |-> !pin_low);

  p_top_lane_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b01 && at_xdata && !ior_ni) |-> (!rd_be_o[NLANE-1] && pin_low));

  p_shadow_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iow_ni && at_xdata) ##1 iow_ni |=> (shadow_q == $past(wdata_i, 2)));
endmodule

bind gpstb_port_ctrl gpstb_port_ctrl_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_W(CTRL_W), .XDATA_IDX(XDATA_IDX)
) chk_i (.*);

// File: tb/gpstb_port_ctrl_tb_top.sv
module gpstb_port_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        port;
  logic [15:0] wdata;
  logic        iow_n;
  logic        ior_n;
  logic [15:0] rdata;
  logic [1:0]  rd_be;
  logic        stb;
  logic        stb_oe;

  int n_chk  = 0;
  int n_fail = 0;

  // behavioural model state
  logic [7:0]  m_idx;
  logic [7:0]  m_ctrl;
  logic [15:0] m_sh;
  logic        m_iow_prev;
  logic        m_port_c;
  logic [15:0] m_wd_c;

  always #4 clk = !clk;

  gpstb_port_ctrl dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .port_i  (port),
    .wdata_i (wdata),
    .iow_ni  (iow_n),
    .ior_ni  (ior_n),
    .rdata_o (rdata),
    .rd_be_o (rd_be),
    .stb_o   (stb),
    .stb_oe_o(stb_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_ctrl = 0; m_sh = 0;
      m_iow_prev = 1; m_port_c = 0; m_wd_c = 0;
    end else begin
      if (!m_iow_prev && iow_n) begin
        if (!m_port_c) m_idx = m_wd_c[7:0];
        else if (m_idx == 8'h0A) m_sh = m_wd_c;
        else if (m_idx == 8'h0B) m_ctrl = m_wd_c[7:0];
      end
      m_iow_prev = iow_n;
      if (!iow_n) begin
        m_port_c = port;
        m_wd_c = wdata;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cmp(input string tag);
    logic [1:0]  md;
    logic        hit, act, pp;
    logic [15:0] ev;
    logic [1:0]  eb;
    md  = m_ctrl[4:3];
    hit = port && (m_idx == 8'h0A);
    act = hit && ((md == 2'b10 && !iow_n) || (md == 2'b01 && !ior_n));
    pp  = m_ctrl[2];
    chk(tag, "stb_o", int'(stb), int'(pp ? !act : 1'b0));
    chk(tag, "stb_oe_o", int'(stb_oe), int'(pp ? 1'b1 : act));
    if (ior_n) begin
      ev = 0; eb = 0;
    end else begin
      if (!port) ev = {8'h00, m_idx};
      else if (m_idx == 8'h0A) ev = m_sh;
      else if (m_idx == 8'h0B) ev = {8'h00, m_ctrl};
      else ev = 0;
      eb = 2'b11;
      if (md == 2'b01 && hit) begin
        eb = 2'b01; ev[15:8] = 0;
      end
    end
    chk(tag, "rdata_o", int'(rdata), int'(ev));
    chk(tag, "rd_be_o", int'(rd_be), int'(eb));
  endtask

  task automatic cyc(input logic p, input logic w, input logic r, input logic [15:0] d,
                     input string tag);
    port = p; iow_n = w; ior_n = r; wdata = d;
    #2;
    cmp(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic p, input logic [15:0] d, input int len, input string tag);
    for (int i = 0; i < len; i++) cyc(p, 1'b0, 1'b1, d, tag);
    cyc(p, 1'b1, 1'b1, 16'h0, tag);
  endtask

  task automatic rd(input logic p, input int len, input string tag);
    for (int i = 0; i < len; i++) cyc(p, 1'b1, 1'b0, 16'h0, tag);
    cyc(p, 1'b1, 1'b1, 16'h0, tag);
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [15:0] d, input string tag);
    wr(1'b0, {8'h00, i}, 1, tag);
    wr(1'b1, d, 2, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; port = 0; iow_n = 1; ior_n = 1; wdata = 0;
    @(negedge clk); @(negedge clk);
    #2 cmp("R1");
    rst_n = 1;
    @(negedge clk);
    cyc(0, 1, 1, 0, "R1");
    rd(0, 1, "R1");
    wr(0, 16'h000A, 1, "R1");
    rd(1, 2, "R1");

    // R2: index and control access
    reg_wr(8'h0B, 16'h0004, "R2");
    rd(1, 1, "R2");
    rd(0, 1, "R2");

    // R9: inactive modes, ordinary register
    reg_wr(8'h0A, 16'h1234, "R9");
    rd(1, 2, "R9");
    reg_wr(8'h0B, 16'h001C, "R9");
    wr(0, 16'h000A, 1, "R9");
    wr(1, 16'hBEEF, 3, "R9");
    rd(1, 2, "R9");

    // R3/R4/R6: write strobe, open-drain then push-pull
    reg_wr(8'h0B, 16'h0010, "R3");
    wr(0, 16'h000A, 1, "R4");
    wr(1, 16'hA5C3, 4, "R4");
    rd(1, 2, "R6");
    reg_wr(8'h0B, 16'h0014, "R8");
    wr(0, 16'h000A, 1, "R8");
    wr(1, 16'h00FF, 2, "R4");
    rd(1, 1, "R6");

    // R5: write end and read start in one cycle
    cyc(1, 0, 1, 16'h3C3C, "R5");
    cyc(1, 1, 0, 16'h0000, "R5");
    cyc(1, 1, 0, 16'h0000, "R5");
    cyc(1, 1, 1, 16'h0000, "R5");

    // R10: other indices in write-strobe mode
    wr(0, 16'h0005, 1, "R10");
    wr(1, 16'hFFFF, 2, "R10");
    rd(1, 2, "R10");

    // R7: read strobe, open-drain then push-pull
    reg_wr(8'h0B, 16'h0008, "R3");
    wr(0, 16'h000A, 1, "R7");
    rd(1, 3, "R7");
    wr(1, 16'h5A5A, 2, "R5");
    rd(1, 1, "R7");
    reg_wr(8'h0B, 16'h000C, "R8");
    wr(0, 16'h000A, 1, "R7");
    rd(1, 2, "R7");
    wr(0, 16'h0003, 1, "R10");
    rd(1, 2, "R10");

    // random traffic compared every cycle
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] k;
      logic [15:0] d;
      k = 3'($urandom);
      d = 16'($urandom);
      if (k == 0) d = {d[15:8], 4'h0, 3'b101, d[0]};
      cyc(1'($urandom), !(k < 3), !(k == 3 || k == 4), d, "R3");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule